// File: doc/BRIEF.md
# Supply and Manual Reset Supervisor

This block produces the system reset for a digital subsystem. It watches a supply-good flag from an external voltage comparator. It holds reset while the supply is low and for a fixed minimum timeout after the supply recovers. Short supply dropouts are filtered out. The flag must stay low for a parameterized number of consecutive samples before it counts as a real brownout.

The reset line can also be shared with other devices. In the open-drain configuration, an external switch or device may pull the line low to request a manual reset. A low held for at least the qualification window is a valid request. The timeout starts when the line is released, not when it is pressed. Shorter lows are ignored. While the block pulls the line low itself, it does not sense the line, so its own pulse cannot retrigger it. While a manual hold is in progress, the block leaves the line to the external source. It takes the line back when the timeout starts.

In the two push-pull configurations the output is always driven. The request input is then read all the time as a separate active-low sense line. All timing values are given in clock cycles. Both inputs pass through a two-flop synchronizer before they are qualified.

Top module: `rst_supervisor`

## Requirements
- R1: While `rst` is high the block signals reset. The stored state comes up as "supply low", so the first timeout runs only once the synchronized supply flag is good.
- R2: With the supply good from the start, reset ends at the clock edge that comes TIMEOUT_CYC+3 edges after the first edge with `rst` low. Until then, reset stays held.
- R3: Let k be the first edge at which `supply_ok_i` is sampled low. If the flag stays low for at least SUP_FILT_CYC consecutive samples, reset is signalled from edge k+SUP_FILT_CYC+2. This latency includes the two synchronizer flops.
- R4: A supply-low run shorter than SUP_FILT_CYC samples has no effect on the output.
- R5: Let j be the first edge at which the supply is sampled good again after a qualified drop. Reset ends at edge j+TIMEOUT_CYC+3.
- R6: A low on `rst_pin_i` held for at least MR_QUAL_CYC consecutive unmasked samples is a manual request. With k as the first low sample, reset is signalled from edge k+MR_QUAL_CYC+2.
- R7: A low on `rst_pin_i` shorter than MR_QUAL_CYC samples has no effect on the output.
- R8: For a manual request, the timeout counts from the release. With j as the first high sample, reset ends at edge j+TIMEOUT_CYC+3.
- R9: A new qualified manual request during a running timeout keeps reset held. The timeout then restarts from the new release.
- R10: A new qualified supply drop during a running timeout keeps reset held. The timeout then restarts only after the supply recovers.
- R11: Output encoding, selected by the parameter OUT_MODE:
  - DRV_PP_HIGH: reset is `rst_pin_o`=1, idle is 0, and `rst_pin_oe_o`=1 at all times.
  - DRV_PP_LOW: reset is `rst_pin_o`=0, idle is 1, and `rst_pin_oe_o`=1 at all times.
  - DRV_OD_LOW: `rst_pin_o` is always 0, and `rst_pin_oe_o`=1 pulls the shared line low.
- R12: In DRV_OD_LOW mode:
  - The line is not pulled during a manual hold.
  - Samples of the line are ignored while the block pulls it and for SYNC_STAGES cycles after it lets go.
  - So the block's own pulse never starts a manual request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| supply_ok_i | input | 1 | Supply-good flag from the external comparator, asynchronous |
| rst_pin_i | input | 1 | Sensed level of the reset line, or the separate active-low request line in push-pull modes |
| rst_pin_o | output | 1 | Driven level for the reset line |
| rst_pin_oe_o | output | 1 | Drive enable for the reset line; in open-drain mode, 1 pulls the line low |

## Verification
The bench builds three copies of the block, all with TIMEOUT_CYC=40, MR_QUAL_CYC=6 and SUP_FILT_CYC=5. One copy is open-drain with the line modelled as a wired pull-up. The other two are push-pull active-low and push-pull active-high, and they share a request line. With these short windows, the exact qualification boundaries (one sample short and exactly long enough) can be reached in a few hundred cycles. So can both restart cases and the release-versus-retrigger masking of the open-drain line.

// File: rtl/rstsup_pkg.sv
package rstsup_pkg;

    typedef enum logic [1:0] {
        DRV_PP_HIGH = 2'd0,
        DRV_PP_LOW  = 2'd1,
        DRV_OD_LOW  = 2'd2
    } drive_mode_e;

    typedef enum logic [1:0] {
        ST_SUP_HOLD = 2'd0,
        ST_MR_HOLD  = 2'd1,
        ST_TIMEOUT  = 2'd2,
        ST_RUN      = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic level;
        logic enable;
    } pin_drive_t;

    function automatic int count_width(input int limit);
        return (limit > 1) ? $clog2(limit + 1) : 1;
    endfunction

    function automatic pin_drive_t encode_pin(input drive_mode_e mode,
                                              input logic asserted,
                                              input logic pull);
        pin_drive_t p;
        case (mode)
            DRV_PP_HIGH: begin p.level = asserted;  p.enable = 1'b1; end
            DRV_PP_LOW:  begin p.level = ~asserted; p.enable = 1'b1; end
            default:     begin p.level = 1'b0;      p.enable = pull; end
        endcase
        return p;
    endfunction

endpackage

// File: rtl/rstsup_sync.sv
module rstsup_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RESET_VAL;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rstsup_low_qual.sv
module rstsup_low_qual #(
    parameter int   MIN_CYC    = 6,
    parameter logic RESET_QUAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic sample_low,
    output logic qualified
);
    import rstsup_pkg::*;

    localparam int QW = count_width(MIN_CYC);
    localparam logic [QW-1:0] LIMIT = QW'(MIN_CYC);

    logic [QW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst)              run_q <= RESET_QUAL ? LIMIT : '0;
        else if (!sample_low) run_q <= '0;
        else if (run_q != LIMIT) run_q <= run_q + 1'b1;
    end

    assign qualified = (run_q == LIMIT);

    // R3 and R6: a qualified level needs a low sample at the previous edge
    assert_qual_follows_low_R3: assert property (@(posedge clk) disable iff (rst)
        (qualified && !$past(rst)) |-> $past(sample_low));

    assert_run_bounded_R7: assert property (@(posedge clk) disable iff (rst)
        run_q <= LIMIT);
endmodule

// File: rtl/rstsup_seq.sv
module rstsup_seq #(
    parameter int TIMEOUT_CYC = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic sup_bad,
    input  logic mr_hold,
    output logic asserted_q,
    output logic pull_q
);
    import rstsup_pkg::*;

    localparam int CW = count_width(TIMEOUT_CYC);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

    seq_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (sup_bad) begin
            state_d = ST_SUP_HOLD;
            cnt_d   = '0;
        end else if (mr_hold) begin
            state_d = ST_MR_HOLD;
            cnt_d   = '0;
        end else begin
            case (state_q)
                ST_SUP_HOLD, ST_MR_HOLD: begin
                    state_d = ST_TIMEOUT;
                    cnt_d   = '0;
                end
                ST_TIMEOUT: begin
                    if (cnt_q == LAST) begin
                        state_d = ST_RUN;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_RUN:  state_d = ST_RUN;
                default: state_d = ST_SUP_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_SUP_HOLD;
            cnt_q      <= '0;
            asserted_q <= 1'b1;
            pull_q     <= 1'b1;
        end else begin
            state_q    <= state_d;
            cnt_q      <= cnt_d;
            asserted_q <= (state_d != ST_RUN);
            pull_q     <= (state_d == ST_SUP_HOLD) || (state_d == ST_TIMEOUT);
        end
    end

    assert_supply_holds_R3: assert property (@(posedge clk) disable iff (rst)
        sup_bad |=> (state_q == ST_SUP_HOLD) && asserted_q);

    assert_manual_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (mr_hold && !sup_bad) |=> (state_q == ST_MR_HOLD) && asserted_q);

    assert_release_after_full_count_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && $past(state_q) != ST_RUN) |->
            ($past(state_q) == ST_TIMEOUT && $past(cnt_q) == LAST));

    // R9 and R10: leaving a timeout for a hold keeps reset signalled
    assert_restart_keeps_reset_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(state_q) == ST_TIMEOUT && state_q != ST_TIMEOUT && state_q != ST_RUN)
            |-> asserted_q);

    assert_count_bounded_R2: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);
endmodule

// File: rtl/rstsup_pin_drv.sv
module rstsup_pin_drv #(
    parameter rstsup_pkg::drive_mode_e OUT_MODE = rstsup_pkg::DRV_OD_LOW,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic asserted,
    input  logic pull,
    output logic pin_level,
    output logic pin_enable,
    output logic sense_mask
);
    import rstsup_pkg::*;

    pin_drive_t drv;

    assign drv        = encode_pin(OUT_MODE, asserted, pull);
    assign pin_level  = drv.level;
    assign pin_enable = drv.enable;

    generate
        if (OUT_MODE == DRV_OD_LOW) begin : g_od_mask
            logic [SYNC_STAGES-1:0] hist_q;
            always_ff @(posedge clk) begin
                if (rst) hist_q <= '1;
                else     hist_q <= {hist_q[SYNC_STAGES-2:0], drv.enable};
            end
            assign sense_mask = drv.enable | (|hist_q);

            assert_od_level_low_R11: assert property (@(posedge clk) disable iff (rst)
                pin_level == 1'b0);
        end else begin : g_pp_open
            assign sense_mask = 1'b0;

            assert_pp_always_driven_R11: assert property (@(posedge clk) disable iff (rst)
                pin_enable && (pin_level == (OUT_MODE == DRV_PP_HIGH ? asserted : ~asserted)));
        end
    endgenerate
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
    parameter rstsup_pkg::drive_mode_e OUT_MODE = rstsup_pkg::DRV_OD_LOW,
    parameter int TIMEOUT_CYC  = 20_000_000,
    parameter int MR_QUAL_CYC  = 300,
    parameter int SUP_FILT_CYC = 40,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok_i,
    input  logic rst_pin_i,
    output logic rst_pin_o,
    output logic rst_pin_oe_o
);
    import rstsup_pkg::*;

    logic sup_sync, pin_sync;
    logic sup_bad, mr_hold;
    logic asserted, pull, mask;

    rstsup_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_sup (
        .clk(clk), .rst(rst), .d(supply_ok_i), .q(sup_sync));

    rstsup_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_pin (
        .clk(clk), .rst(rst), .d(rst_pin_i), .q(pin_sync));

    rstsup_low_qual #(.MIN_CYC(SUP_FILT_CYC), .RESET_QUAL(1'b1)) u_qual_sup (
        .clk(clk), .rst(rst), .sample_low(~sup_sync), .qualified(sup_bad));

    rstsup_low_qual #(.MIN_CYC(MR_QUAL_CYC), .RESET_QUAL(1'b0)) u_qual_pin (
        .clk(clk), .rst(rst), .sample_low(~pin_sync & ~mask), .qualified(mr_hold));

    rstsup_seq #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_seq (
        .clk(clk), .rst(rst), .sup_bad(sup_bad), .mr_hold(mr_hold),
        .asserted_q(asserted), .pull_q(pull));

    rstsup_pin_drv #(.OUT_MODE(OUT_MODE), .SYNC_STAGES(SYNC_STAGES)) u_drv (
        .clk(clk), .rst(rst), .asserted(asserted), .pull(pull),
        .pin_level(rst_pin_o), .pin_enable(rst_pin_oe_o), .sense_mask(mask));

    generate
        if (OUT_MODE == DRV_OD_LOW) begin : g_od_chk
            assert_own_pulse_masked_R12: assert property (@(posedge clk) disable iff (rst)
                $past(rst_pin_oe_o) |-> !mr_hold);
        end
    endgenerate
endmodule

// File: tb/rst_supervisor_bench.sv
module rst_supervisor_bench;
    import rstsup_pkg::*;

    localparam int T  = 40;
    localparam int MQ = 6;
    localparam int SF = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic supply_ok = 1'b1;
    logic btn_od = 1'b0;
    logic req_pp_n = 1'b1;
    logic o_od, oe_od, o_lo, oe_lo, o_hi, oe_hi;
    logic pin_od;
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign pin_od = ~(btn_od | oe_od);

    rst_supervisor #(.OUT_MODE(DRV_OD_LOW), .TIMEOUT_CYC(T), .MR_QUAL_CYC(MQ),
                     .SUP_FILT_CYC(SF), .SYNC_STAGES(2)) u_rst_supervisor (
        .clk(clk), .rst(rst), .supply_ok_i(supply_ok), .rst_pin_i(pin_od),
        .rst_pin_o(o_od), .rst_pin_oe_o(oe_od));

    rst_supervisor #(.OUT_MODE(DRV_PP_LOW), .TIMEOUT_CYC(T), .MR_QUAL_CYC(MQ),
                     .SUP_FILT_CYC(SF), .SYNC_STAGES(2)) u_rst_supervisor_lo (
        .clk(clk), .rst(rst), .supply_ok_i(supply_ok), .rst_pin_i(req_pp_n),
        .rst_pin_o(o_lo), .rst_pin_oe_o(oe_lo));

    rst_supervisor #(.OUT_MODE(DRV_PP_HIGH), .TIMEOUT_CYC(T), .MR_QUAL_CYC(MQ),
                     .SUP_FILT_CYC(SF), .SYNC_STAGES(2)) u_rst_supervisor_hi (
        .clk(clk), .rst(rst), .supply_ok_i(supply_ok), .rst_pin_i(req_pp_n),
        .rst_pin_o(o_hi), .rst_pin_oe_o(oe_hi));

    // which: 0 = open-drain copy (val is the expected pull enable),
    //        1 = both push-pull copies (val is the expected reset state)
    typedef struct {
        int    cyc;
        int    which;
        bit    val;
        string tag;
    } exp_t;

    exp_t sb[$];

    task automatic expect_span(input int which, input int c0, input int c1,
                               input bit val, input string tag);
        for (int c = c0; c <= c1; c++) begin
            exp_t e;
            e.cyc = c; e.which = which; e.val = val; e.tag = tag;
            sb.push_back(e);
        end
    endtask

    task automatic goto(input int c);
        do @(negedge clk); while (cyc < c);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // monitor: pops the items due in this cycle and compares them
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].cyc == cyc) begin
                checks++;
                if (sb[i].which == 0) begin
                    if (oe_od !== sb[i].val || o_od !== 1'b0) begin
                        errors++;
                        $display("FAIL %s cyc %0d od: actual o=%b oe=%b expected o=0 oe=%b",
                                 sb[i].tag, cyc, o_od, oe_od, sb[i].val);
                    end
                end else begin
                    if (o_lo !== ~sb[i].val || oe_lo !== 1'b1 ||
                        o_hi !== sb[i].val || oe_hi !== 1'b1) begin
                        errors++;
                        $display("FAIL %s cyc %0d pp: actual lo=%b/%b hi=%b/%b expected lo=%b/1 hi=%b/1",
                                 sb[i].tag, cyc, o_lo, oe_lo, o_hi, oe_hi, ~sb[i].val, sb[i].val);
                    end
                end
                sb.delete(i);
            end
        end
    end

    initial begin
        // driver: expected results first, computed from the requirement latencies
        expect_span(0, 1, 3, 1'b1, "R1");
        expect_span(1, 1, 3, 1'b1, "R1");
        expect_span(0, 4, 46, 1'b1, "R2");
        expect_span(1, 4, 46, 1'b1, "R2");
        expect_span(0, 47, 99, 1'b0, "R2");
        expect_span(1, 47, 99, 1'b0, "R2");
        expect_span(1, 100, 199, 1'b0, "R7");
        expect_span(0, 100, 299, 1'b0, "R7");
        expect_span(1, 200, 208, 1'b0, "R6");
        expect_span(1, 209, 249, 1'b1, "R6");
        expect_span(1, 250, 408, 1'b0, "R8");
        expect_span(0, 300, 323, 1'b0, "R12");
        expect_span(0, 324, 363, 1'b1, "R8");
        expect_span(0, 364, 499, 1'b0, "R12");
        expect_span(1, 409, 481, 1'b1, "R9");
        expect_span(1, 482, 499, 1'b0, "R9");
        expect_span(0, 500, 607, 1'b0, "R4");
        expect_span(1, 500, 607, 1'b0, "R4");
        expect_span(0, 608, 653, 1'b1, "R3");
        expect_span(1, 608, 653, 1'b1, "R3");
        expect_span(0, 654, 707, 1'b0, "R5");
        expect_span(1, 654, 707, 1'b0, "R5");
        expect_span(0, 708, 781, 1'b1, "R10");
        expect_span(1, 708, 781, 1'b1, "R10");
        expect_span(0, 782, 807, 1'b0, "R10");
        expect_span(1, 782, 807, 1'b0, "R10");
        expect_span(0, 808, 848, 1'b1, "R3");
        expect_span(1, 808, 848, 1'b1, "R3");
        expect_span(0, 849, 900, 1'b0, "R5");
        expect_span(1, 849, 900, 1'b0, "R5");

        // stimulus
        goto(3);   rst = 1'b0;
        goto(100); req_pp_n = 1'b0;   // R7: 5 samples, one short
        goto(105); req_pp_n = 1'b1;
        goto(140); btn_od = 1'b1;     // R7: open-drain, 5 samples
        goto(145); btn_od = 1'b0;
        goto(200); req_pp_n = 1'b0;   // R6: exactly MQ samples
        goto(206); req_pp_n = 1'b1;
        goto(300); btn_od = 1'b1;     // R8/R12: long open-drain hold
        goto(320); btn_od = 1'b0;
        goto(400); req_pp_n = 1'b0;   // R9: request then re-request in timeout
        goto(410); req_pp_n = 1'b1;
        goto(430); req_pp_n = 1'b0;
        goto(438); req_pp_n = 1'b1;
        goto(500); supply_ok = 1'b0;  // R4: 4-sample dropout
        goto(504); supply_ok = 1'b1;
        goto(600); supply_ok = 1'b0;  // R3/R5: 10-sample drop
        goto(610); supply_ok = 1'b1;
        goto(700); supply_ok = 1'b0;  // R10: drop, recover, drop in timeout
        goto(710); supply_ok = 1'b1;
        goto(730); supply_ok = 1'b0;
        goto(738); supply_ok = 1'b1;
        goto(800); supply_ok = 1'b0;  // R3: exactly SF samples
        goto(805); supply_ok = 1'b1;
        goto(902);

        if (sb.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL R1 scoreboard: actual %0d items unchecked expected 0", sb.size());
        end
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog: actual cyc %0d expected finish by 902", cyc);
            summary();
            $finish;
        end
    end
endmodule